// File: doc/BRIEF.md
# Wavefront Initial Scalar Register Loader

Before a wavefront starts, its scalar registers must hold a set of launch values. These include buffer descriptor words, several 64-bit pointers, scratch sizing, work-group counts, work-group identifiers and a per-wave scratch offset. This block takes a word of per-field enable bits together with the dispatch values. It then emits one register write per clock. Each write carries a register index and a 32-bit value.

Enabled fields are numbered densely from register 0 in a fixed order. A disabled field consumes no register number. The user-data fields come first, and at most 16 user registers are ever written. Any further user words are dropped without notice. The system fields follow straight after the last written user register. The block also computes the work-group count for each dimension from the grid and work-group sizes. It reports the number of user registers it wrote. A start/busy/done handshake frames each load sequence.

Top module: `wave_init_loader`

## Requirements
- R1: While reset is active and after its release, `busy_o`, `done_o`, `wr_en_o` and `error_o` are 0 and `user_cnt_o` is 0.
- R2: A `start_i` sampled while idle raises `busy_o` on the next clock edge. From that cycle there is exactly one write per clock, with `wr_idx_o` running 0, 1, 2 and so on. A `start_i` sampled while busy is ignored and does not restart the index.
- R3: `done_o` is high for exactly one cycle, namely the cycle right after the last write. In that cycle `busy_o` and `wr_en_o` are already 0.
- R4: The user fields are emitted in the following order. Each is controlled by the `props_i` bit given in parentheses, and the word count follows the colon:
  - segment buffer descriptor (bit 0): 4 words, `seg_buf_i` lowest 32 bits first
  - dispatch pointer (bit 1): 2 words
  - queue pointer (bit 2): 2 words
  - kernel-argument pointer (bit 3): 2 words
  - dispatch ID (bit 4): 2 words
  - flat scratch init (bit 5): 2 words, `scratch_off_i` first, then the rounded per-item size
  - per-item private size (bit 6): 1 word
  - work-group count X, Y, Z (bits 7, 8, 9): 1 word each
- R5: Each 64-bit field is written as two consecutive registers. Bits 31:0 go in the lower-numbered register and bits 63:32 in the next one.
- R6: Only the first 16 enabled user words are written, and any later user words are dropped. `user_cnt_o` reports the number written, clamped to 16, and holds it from the cycle after start.
- R7: The work-group count of a dimension is (grid + size − 1) / size, using integer division and 32-bit operands. The X, Y and Z dimensions occupy bits 31:0, 63:32 and 95:64 of `grid_i` and `wg_size_i`.
- R8: When a work-group size is 0, that dimension's count word is 0. In that case `error_o` is 1 from the cycle after start until the next accepted start.
- R9: The system words follow the last user word with no gap, in this order:
  - work-group ID X (always written)
  - ID Y (`sys_en_i[0]`)
  - ID Z (`sys_en_i[1]`)
  - work-group info (`sys_en_i[2]`)
  - wave scratch offset (`sys_en_i[3]`)
- R10: The work-group info word is formed as follows:
  - bit 31: `first_wave_i`
  - bits 30:17: zero
  - bits 16:6: `ordered_term_i`
  - bits 5:0: `wave_cnt_i`
- R11: Both size words (flat scratch init second word and per-item private size) carry `item_priv_bytes_i` rounded up to a multiple of 4.
- R12: A field whose enable bit is 0 takes no register number. The next enabled field takes the index the skipped field would have used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load sequence when idle |
| props_i | input | 10 | User field enable bits |
| sys_en_i | input | 4 | System field enables: ID Y, ID Z, info, wave offset |
| seg_buf_i | input | 128 | Segment buffer descriptor |
| disp_ptr_i | input | 64 | Dispatch pointer |
| queue_ptr_i | input | 64 | Queue pointer |
| karg_ptr_i | input | 64 | Kernel-argument pointer |
| disp_id_i | input | 64 | Dispatch identifier |
| scratch_off_i | input | 32 | Scratch byte offset for flat scratch init |
| item_priv_bytes_i | input | 32 | Per-work-item private byte size |
| grid_i | input | 96 | Grid size, X/Y/Z |
| wg_size_i | input | 96 | Work-group size, X/Y/Z |
| wg_id_i | input | 96 | Work-group ID, X/Y/Z |
| first_wave_i | input | 1 | First-wave flag |
| ordered_term_i | input | 11 | Ordered-append term |
| wave_cnt_i | input | 6 | Work-group size in waves |
| wave_off_i | input | 32 | Wave scratch byte offset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| wr_en_o | output | 1 | Register write valid |
| wr_idx_o | output | 5 | Destination register index |
| wr_data_o | output | 32 | Register write value |
| user_cnt_o | output | 5 | User registers written, clamped to 16 |
| error_o | output | 1 | A work-group size was zero |

## Verification
A corrupted pending mask or index counter is visible at the ports at once. It shows up within the same sequence as a repeated or skipped `wr_idx_o`, a word out of field order, or a wrong count of writes before `done_o`. A cap applied at the wrong point shifts every system word to the wrong register. This appears in the first sequence whose enabled user words exceed 16. An error in rounding or division shows in the affected data word as soon as that field is written.

// File: rtl/wil_pkg.sv
package wil_pkg;
  localparam int DW         = 32;
  localparam int PROP_W     = 10;
  localparam int SYS_EN_W   = 4;
  localparam int USER_WORDS = 18;
  localparam int SYS_WORDS  = 5;
  localparam int ALL_WORDS  = USER_WORDS + SYS_WORDS;
  localparam int SEL_W      = $clog2(ALL_WORDS);

  // enable bit governing each user word slot
  function automatic int prop_of_word(input int w);
    if (w < 4)       return 0;
    else if (w < 14) return 1 + (w - 4) / 2;
    else             return w - 8;
  endfunction

  function automatic logic [DW-1:0] round_dword(input logic [DW-1:0] v);
    return (v + DW'(3)) & ~DW'(3);
  endfunction
endpackage

// File: rtl/wil_slot_mask.sv
module wil_slot_mask
  import wil_pkg::*;
#(
  parameter int USER_CAP = 16,
  localparam int CNT_W = $clog2(USER_CAP + 1)
) (
  input  logic [PROP_W-1:0]    props_i,
  input  logic [SYS_EN_W-1:0]  sys_en_i,
  output logic [ALL_WORDS-1:0] mask_o,
  output logic [CNT_W-1:0]     user_cnt_o
);
  int taken;

  always_comb begin
    mask_o = '0;
    taken  = 0;
    for (int w = 0; w < USER_WORDS; w++) begin
      if (props_i[prop_of_word(w)] && taken < USER_CAP) begin
        mask_o[w] = 1'b1;
        taken++;
      end
    end
    mask_o[USER_WORDS] = 1'b1;
    for (int k = 0; k < SYS_EN_W; k++) mask_o[USER_WORDS+1+k] = sys_en_i[k];
    user_cnt_o = CNT_W'(taken);
  end
endmodule

// File: rtl/wil_wg_count.sv
module wil_wg_count #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] grid_i,
  input  logic [DW-1:0] size_i,
  output logic [DW-1:0] cnt_o,
  output logic          zero_o
);
  logic [DW:0] sum, quo;

  always_comb begin
    zero_o = (size_i == '0);
    sum    = {1'b0, grid_i} + {1'b0, size_i} - (DW+1)'(1);
    quo    = zero_o ? '0 : sum / {1'b0, size_i};
    cnt_o  = quo[DW-1:0];
  end
endmodule

// File: rtl/wil_word_sel.sv
module wil_word_sel
  import wil_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [4*DW-1:0]  seg_buf_i,
  input  logic [2*DW-1:0]  disp_ptr_i,
  input  logic [2*DW-1:0]  queue_ptr_i,
  input  logic [2*DW-1:0]  karg_ptr_i,
  input  logic [2*DW-1:0]  disp_id_i,
  input  logic [DW-1:0]    scratch_off_i,
  input  logic [DW-1:0]    item_priv_bytes_i,
  input  logic [3*DW-1:0]  wg_cnt_i,
  input  logic [3*DW-1:0]  wg_id_i,
  input  logic             first_wave_i,
  input  logic [10:0]      ordered_term_i,
  input  logic [5:0]       wave_cnt_i,
  input  logic [DW-1:0]    wave_off_i,
  output logic [DW-1:0]    word_o
);
  logic [DW-1:0] words [ALL_WORDS];
  logic [DW-1:0] size_rnd;

  assign size_rnd = round_dword(item_priv_bytes_i);

  always_comb begin
    for (int i = 0; i < 4; i++) words[i] = seg_buf_i[i*DW +: DW];
    for (int h = 0; h < 2; h++) begin
      words[4+h]  = disp_ptr_i[h*DW +: DW];
      words[6+h]  = queue_ptr_i[h*DW +: DW];
      words[8+h]  = karg_ptr_i[h*DW +: DW];
      words[10+h] = disp_id_i[h*DW +: DW];
    end
    words[12] = scratch_off_i;
    words[13] = size_rnd;
    words[14] = size_rnd;
    for (int d = 0; d < 3; d++) begin
      words[15+d] = wg_cnt_i[d*DW +: DW];
      words[18+d] = wg_id_i[d*DW +: DW];
    end
    words[21] = {first_wave_i, 14'b0, ordered_term_i, wave_cnt_i};
    words[22] = wave_off_i;
  end

  assign word_o = (int'(sel_i) < ALL_WORDS) ? words[sel_i] : '0;
endmodule

// File: rtl/wave_init_loader.sv
module wave_init_loader
  import wil_pkg::*;
#(
  parameter int USER_CAP = 16,
  localparam int IDX_W = $clog2(USER_CAP + SYS_WORDS),
  localparam int CNT_W = $clog2(USER_CAP + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PROP_W-1:0]   props_i,
  input  logic [SYS_EN_W-1:0] sys_en_i,
  input  logic [4*DW-1:0]     seg_buf_i,
  input  logic [2*DW-1:0]     disp_ptr_i,
  input  logic [2*DW-1:0]     queue_ptr_i,
  input  logic [2*DW-1:0]     karg_ptr_i,
  input  logic [2*DW-1:0]     disp_id_i,
  input  logic [DW-1:0]       scratch_off_i,
  input  logic [DW-1:0]       item_priv_bytes_i,
  input  logic [3*DW-1:0]     grid_i,
  input  logic [3*DW-1:0]     wg_size_i,
  input  logic [3*DW-1:0]     wg_id_i,
  input  logic                first_wave_i,
  input  logic [10:0]         ordered_term_i,
  input  logic [5:0]          wave_cnt_i,
  input  logic [DW-1:0]       wave_off_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [DW-1:0]       wr_data_o,
  output logic [CNT_W-1:0]    user_cnt_o,
  output logic                error_o
);
  logic [ALL_WORDS-1:0] mask, pending_q, sel_onehot, pending_nxt;
  logic [CNT_W-1:0]     cnt_now, user_cnt_q;
  logic [3*DW-1:0]      wg_cnt;
  logic [2:0]           wg_zero;
  logic [SEL_W-1:0]     sel;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q, done_q, error_q;

  wil_slot_mask #(.USER_CAP(USER_CAP)) u_mask (
    .props_i   (props_i),
    .sys_en_i  (sys_en_i),
    .mask_o    (mask),
    .user_cnt_o(cnt_now)
  );

  for (genvar d = 0; d < 3; d++) begin : g_dim
    wil_wg_count #(.DW(DW)) u_cnt (
      .grid_i(grid_i[d*DW +: DW]),
      .size_i(wg_size_i[d*DW +: DW]),
      .cnt_o (wg_cnt[d*DW +: DW]),
      .zero_o(wg_zero[d])
    );
  end

  // lowest pending slot is next to write
  always_comb begin
    sel = '0;
    for (int i = ALL_WORDS - 1; i >= 0; i--) if (pending_q[i]) sel = SEL_W'(i);
    sel_onehot  = ALL_WORDS'(1) << sel;
    pending_nxt = pending_q & ~sel_onehot;
  end

  wil_word_sel u_sel (
    .sel_i            (sel),
    .seg_buf_i        (seg_buf_i),
    .disp_ptr_i       (disp_ptr_i),
    .queue_ptr_i      (queue_ptr_i),
    .karg_ptr_i       (karg_ptr_i),
    .disp_id_i        (disp_id_i),
    .scratch_off_i    (scratch_off_i),
    .item_priv_bytes_i(item_priv_bytes_i),
    .wg_cnt_i         (wg_cnt),
    .wg_id_i          (wg_id_i),
    .first_wave_i     (first_wave_i),
    .ordered_term_i   (ordered_term_i),
    .wave_cnt_i       (wave_cnt_i),
    .wave_off_i       (wave_off_i),
    .word_o           (wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q  <= '0;
      idx_q      <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      user_cnt_q <= '0;
      error_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          pending_q  <= mask;
          idx_q      <= '0;
          busy_q     <= 1'b1;
          user_cnt_q <= cnt_now;
          error_q    <= |wg_zero;
        end
      end else begin
        pending_q <= pending_nxt;
        idx_q     <= idx_q + IDX_W'(1);
        if (pending_nxt == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign wr_en_o    = busy_q;
  assign wr_idx_o   = idx_q;
  assign user_cnt_o = user_cnt_q;
  assign error_o    = error_q;
endmodule

// File: rtl/wave_init_loader_checker.sv
module wave_init_loader_checker #(
  parameter int USER_CAP = 16,
  parameter int SYS_WORDS = 5,
  parameter int IDX_W = 5,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic [CNT_W-1:0] user_cnt_o
);
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (int'(wr_idx_o) == int'($past(wr_idx_o)) + 1)); // R2
  AST_IDX_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> (wr_idx_o == '0)); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !wr_en_o)); // R3
  AST_USER_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(user_cnt_o) <= USER_CAP); // R6
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (int'(wr_idx_o) < int'(user_cnt_o) + SYS_WORDS)); // R9
endmodule

bind wave_init_loader wave_init_loader_checker #(
  .USER_CAP (USER_CAP),
  .SYS_WORDS(wil_pkg::SYS_WORDS),
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .wr_en_o   (wr_en_o),
  .wr_idx_o  (wr_idx_o),
  .user_cnt_o(user_cnt_o)
);

// File: tb/wave_init_loader_bench.sv
module wave_init_loader_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [9:0]   props = '0;
  logic [3:0]   sys_en = '0;
  logic [127:0] seg_buf = {32'hB0B0_0003, 32'hB0B0_0002, 32'hB0B0_0001, 32'hB0B0_0000};
  logic [63:0]  disp_ptr = 64'hD1D1_0001_D0D0_0000;
  logic [63:0]  queue_ptr = 64'hC1C1_0011_C0C0_0010;
  logic [63:0]  karg_ptr = 64'hA1A1_0021_A0A0_0020;
  logic [63:0]  disp_id = 64'hE1E1_0031_E0E0_0030;
  logic [31:0]  scratch_off = 32'h0000_5A00;
  logic [31:0]  priv_bytes = 32'd13;
  logic [95:0]  grid = {32'd1, 32'd64, 32'd100};
  logic [95:0]  wg_size = {32'd4, 32'd16, 32'd16};
  logic [95:0]  wg_id = {32'h0000_0ED2, 32'h0000_0ED1, 32'h0000_0ED0};
  logic         first_wave = 1'b1;
  logic [10:0]  ord_term = 11'h5A5;
  logic [5:0]   wave_cnt = 6'd9;
  logic [31:0]  wave_off = 32'h0000_7700;

  logic         busy, done, wr_en, err;
  logic [4:0]   wr_idx, user_cnt;
  logic [31:0]  wr_data;

  always #4 clk = ~clk;

  wave_init_loader u_wave_init_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .props_i(props), .sys_en_i(sys_en),
    .seg_buf_i(seg_buf), .disp_ptr_i(disp_ptr), .queue_ptr_i(queue_ptr),
    .karg_ptr_i(karg_ptr), .disp_id_i(disp_id), .scratch_off_i(scratch_off),
    .item_priv_bytes_i(priv_bytes), .grid_i(grid), .wg_size_i(wg_size), .wg_id_i(wg_id),
    .first_wave_i(first_wave), .ordered_term_i(ord_term), .wave_cnt_i(wave_cnt),
    .wave_off_i(wave_off), .busy_o(busy), .done_o(done), .wr_en_o(wr_en),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data), .user_cnt_o(user_cnt), .error_o(err)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  logic [31:0] exp_d [32];
  int exp_n, exp_u;
  logic [31:0] got_d [32];
  int got_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] wg_div(input logic [31:0] g, input logic [31:0] w);
    if (w == 0) return 32'd0;
    return 32'((64'(g) + 64'(w) - 64'd1) / 64'(w));
  endfunction

  task automatic build_exp(input logic [9:0] p, input logic [3:0] s);
    logic [31:0] uw [18];
    logic [31:0] rs;
    int fld [18];
    rs = ((priv_bytes + 32'd3) / 32'd4) * 32'd4;
    for (int i = 0; i < 4; i++) begin uw[i] = seg_buf[i*32 +: 32]; fld[i] = 0; end
    uw[4] = disp_ptr[31:0];   uw[5] = disp_ptr[63:32];
    uw[6] = queue_ptr[31:0];  uw[7] = queue_ptr[63:32];
    uw[8] = karg_ptr[31:0];   uw[9] = karg_ptr[63:32];
    uw[10] = disp_id[31:0];   uw[11] = disp_id[63:32];
    uw[12] = scratch_off;     uw[13] = rs;  uw[14] = rs;
    for (int k = 4; k < 14; k++) fld[k] = 1 + (k - 4) / 2;
    fld[14] = 6;
    for (int d = 0; d < 3; d++) begin
      uw[15+d] = wg_div(grid[d*32 +: 32], wg_size[d*32 +: 32]);
      fld[15+d] = 7 + d;
    end
    exp_n = 0;
    for (int w = 0; w < 18; w++)
      if (p[fld[w]] && exp_n < 16) begin exp_d[exp_n] = uw[w]; exp_n++; end
    exp_u = exp_n;
    exp_d[exp_n] = wg_id[31:0]; exp_n++;
    if (s[0]) begin exp_d[exp_n] = wg_id[63:32]; exp_n++; end
    if (s[1]) begin exp_d[exp_n] = wg_id[95:64]; exp_n++; end
    if (s[2]) begin exp_d[exp_n] = {first_wave, 14'b0, ord_term, wave_cnt}; exp_n++; end
    if (s[3]) begin exp_d[exp_n] = wave_off; exp_n++; end
  endtask

  task automatic run_seq(input logic [9:0] p, input logic [3:0] s, input bit restart);
    int wd;
    build_exp(p, s);
    @(negedge clk);
    props = p; sys_en = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_n = 0; wd = 0;
    while (!done && wd < 64) begin
      if (wr_en) begin
        chk(int'(wr_idx) == got_n, "R2", "write index", 64'(wr_idx), 64'(got_n));
        if (got_n < 32) begin
          got_d[got_n] = wr_data;
          chk(wr_data == exp_d[got_n], "R4", "write data", 64'(wr_data), 64'(exp_d[got_n]));
        end
        got_n++;
      end
      start = restart && (got_n == 2);
      @(negedge clk);
      start = 1'b0;
      wd++;
    end
    chk(done && !busy && !wr_en, "R3", "done pulse idle", {61'b0, done, busy, wr_en}, 64'h4);
    chk(got_n == exp_n, "R12", "write count", 64'(got_n), 64'(exp_n));
    chk(int'(user_cnt) == exp_u, "R6", "user count", 64'(user_cnt), 64'(exp_u));
    @(negedge clk);
    chk(!done, "R3", "done single cycle", 64'(done), 64'd0);
  endtask

  // {props, sys_en}
  localparam logic [13:0] VEC [9] = '{
    {10'h000, 4'h0}, {10'h3FF, 4'hF}, {10'h001, 4'h0}, {10'h002, 4'h1},
    {10'h380, 4'h4}, {10'h060, 4'h8}, {10'h3FE, 4'h0}, {10'h3BF, 4'h2},
    {10'h07F, 4'hF}
  };

  initial begin
    #5;
    chk(!busy && !done && !wr_en && !err && user_cnt == 0, "R1", "in reset",
        {58'b0, busy, done, wr_en, err, 2'b0}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_en && !err && user_cnt == 0, "R1", "after reset",
        {58'b0, busy, done, wr_en, err, 2'b0}, 64'd0);

    for (int v = 0; v < 9; v++) run_seq(VEC[v][13:4], VEC[v][3:0], 1'b0);

    // R2: start while busy ignored
    run_seq(10'h03F, 4'hF, 1'b1);
    // R5: 64-bit split, R12: skipped fields
    run_seq(10'h002, 4'h0, 1'b0);
    chk(got_d[0] == disp_ptr[31:0] && got_d[1] == disp_ptr[63:32], "R5", "ptr low first",
        {got_d[1], got_d[0]}, disp_ptr);
    run_seq(10'h004, 4'h0, 1'b0);
    chk(got_d[0] == queue_ptr[31:0], "R12", "queue at index 0", 64'(got_d[0]), 64'(queue_ptr[31:0]));
    // R7
    run_seq(10'h380, 4'h0, 1'b0);
    chk(got_d[0] == 7 && got_d[1] == 4 && got_d[2] == 1, "R7", "wg counts",
        {got_d[1], got_d[0]}, {32'd4, 32'd7});
    // R8
    wg_size[63:32] = 32'd0;
    run_seq(10'h380, 4'h0, 1'b0);
    chk(got_d[1] == 0, "R8", "zero size count", 64'(got_d[1]), 64'd0);
    chk(err, "R8", "error flag set", 64'(err), 64'd1);
    wg_size[63:32] = 32'd16;
    run_seq(10'h380, 4'h0, 1'b0);
    chk(!err, "R8", "error cleared", 64'(err), 64'd0);
    // R9 / R10
    run_seq(10'h000, 4'hF, 1'b0);
    chk(got_d[0] == wg_id[31:0] && got_d[1] == wg_id[63:32] && got_d[2] == wg_id[95:64] &&
        got_d[4] == wave_off, "R9", "system order", {got_d[1], got_d[0]}, wg_id[63:0]);
    chk(got_d[3] == {1'b1, 14'b0, 11'h5A5, 6'd9}, "R10", "info layout",
        64'(got_d[3]), 64'({1'b1, 14'b0, 11'h5A5, 6'd9}));
    // R11
    run_seq(10'h060, 4'h0, 1'b0);
    chk(got_d[0] == scratch_off && got_d[1] == 16 && got_d[2] == 16, "R11", "rounded size",
        {got_d[2], got_d[1]}, {32'd16, 32'd16});
    // R6: cap splits count field Z off
    run_seq(10'h3BF, 4'h0, 1'b0);
    chk(got_d[15] == 4 && got_d[16] == wg_id[31:0] && user_cnt == 16, "R6", "cap drop",
        {got_d[16], got_d[15]}, {wg_id[31:0], 32'd4});

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule